// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits on the request side of a memory target and makes semaphore-style read-then-write pairs work without locking the bus. Each requester ID owns one reservation slot. An exclusive read from that ID arms the slot with the read address. Ordinary reads pass through without touching the table. Other requesters keep running against other addresses the whole time.

When an exclusive write arrives, the monitor looks up the slot belonging to the writing ID. The pair succeeds only if that slot is armed and holds the same address as the write. On success the write is let through to memory and answered with the okay-exclusive code. On failure the write is blocked and answered with the plain okay code, which tells the requester that its exclusive sequence failed. Any write that actually reaches memory disarms every other slot reserved on that address, so a competing exclusive write from the reserving ID then fails.

The permit and the response are combinational functions of the current write request and the table contents. The table itself changes on the rising clock edge.

Top module: `exmon`

## Requirements
- R1: `wr_resp` uses the code 2'b00 for plain okay and 2'b01 for okay-exclusive. It shows 2'b01 only for a successful exclusive write, and 2'b00 in every other case, including idle cycles.
- R2: An exclusive read (`rd_valid` and `rd_excl` both high) arms the slot of `rd_id` with `rd_addr`. A later exclusive write with the same ID and the same address then gets `wr_permit`=1 and `wr_resp`=2'b01 in its own cycle.
- R3: An exclusive write gets `wr_permit`=0 and `wr_resp`=2'b00 if the slot of its ID is not armed, or if the slot holds a different address.
- R4: Every exclusive write disarms the slot of its own ID at the next clock edge, whether it succeeds or fails. An immediate repeat of the same exclusive write therefore fails.
- R5: A write that is permitted disarms every armed slot whose stored address equals the write address. This applies to a plain write and to a successful exclusive write, whatever the ID of the writer.
- R6: A failed exclusive write leaves the slots of all other IDs unchanged.
- R7: A non-exclusive write always gets `wr_permit`=1 and `wr_resp`=2'b00. With `wr_valid` low, `wr_permit` is 0.
- R8: A new exclusive read from an ID replaces that ID's earlier reservation. After it, only the newer address can succeed.
- R9: A non-exclusive read has no effect on any slot.
- R10: Synchronous active-high reset disarms all slots.
- R11: Reads and writes presented in the same cycle are resolved as follows. The write is judged against the table as it was before the edge. An exclusive read in that cycle then arms its slot after the write's clearing, so the new reservation survives.
- R12: Reservations of different IDs are independent. Exclusive reads from other IDs and writes to other addresses do not disturb a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | A read request is presented this cycle |
| rd_id | input | ID_W | Requester ID of the read |
| rd_addr | input | ADDR_W | Target address of the read |
| rd_excl | input | 1 | The read is exclusive |
| wr_valid | input | 1 | A write request is presented this cycle |
| wr_id | input | ID_W | Requester ID of the write |
| wr_addr | input | ADDR_W | Target address of the write |
| wr_excl | input | 1 | The write is exclusive |
| wr_permit | output | 1 | The write may update memory |
| wr_resp | output | 2 | Response code for the write |

## Verification
The bench builds the monitor with ID_W=3, which gives eight slots, and ADDR_W=16. The random phase draws IDs from the full eight-value range but addresses from only four values. This makes reservation hits, cross-ID invalidations and same-cycle read/write collisions frequent rather than rare. Directed sequences before the random phase pin down the following cases:
- reset in the middle of a live reservation,
- a reservation being overwritten,
- a non-exclusive read that must be ignored,
- a failed exclusive write that must spare other IDs' reservations,
- a read and a write colliding in the same cycle.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01
    } exmon_resp_e;

    // Outcome of judging one write against the reservation table.
    typedef struct packed {
        logic        permit;
        exmon_resp_e resp;
    } exmon_verdict_t;

    function automatic exmon_verdict_t exmon_judge(input logic valid,
                                                   input logic excl,
                                                   input logic own_hit);
        exmon_verdict_t v;
        v.permit = 1'b0;
        v.resp   = RESP_OKAY;
        if (valid) begin
            if (!excl) begin
                v.permit = 1'b1;
            end else if (own_hit) begin
                v.permit = 1'b1;
                v.resp   = RESP_EXOKAY;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/exmon_slot.sv
// One reservation slot: an armed flag plus the reserved address.
module exmon_slot #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] arm_addr_i,
    input  logic              disarm_i,
    input  logic [ADDR_W-1:0] probe_addr_i,
    output logic              hit_o
);
    typedef struct packed {
        logic              armed;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (arm_i) begin
            slot_q.armed <= 1'b1;
            slot_q.addr  <= arm_addr_i;
        end else if (disarm_i) begin
            slot_q.armed <= 1'b0;
        end
    end

    assign hit_o = slot_q.armed && (slot_q.addr == probe_addr_i);

endmodule

// File: rtl/exmon_ctrl.sv
// Per-slot arm/disarm decode and the write verdict.
module exmon_ctrl
    import exmon_pkg::*;
#(
    parameter int ID_W = 3,
    localparam int SLOTS = 1 << ID_W
) (
    input  logic             rd_valid,
    input  logic [ID_W-1:0]  rd_id,
    input  logic             rd_excl,
    input  logic             wr_valid,
    input  logic [ID_W-1:0]  wr_id,
    input  logic             wr_excl,
    input  logic [SLOTS-1:0] hit_vec,
    output logic [SLOTS-1:0] arm_vec,
    output logic [SLOTS-1:0] disarm_vec,
    output exmon_verdict_t   verdict
);
    logic own_hit;

    assign own_hit = hit_vec[wr_id];
    assign verdict = exmon_judge(wr_valid, wr_excl, own_hit);

    for (genvar i = 0; i < SLOTS; i++) begin : g_dec
        assign arm_vec[i] = rd_valid && rd_excl && (rd_id == ID_W'(i));
        assign disarm_vec[i] = wr_valid &&
                               ((wr_excl && (wr_id == ID_W'(i))) ||
                                (verdict.permit && hit_vec[i]));
    end

endmodule

// File: rtl/exmon.sv
module exmon
    import exmon_pkg::*;
#(
    parameter int ID_W   = 3,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [ID_W-1:0]   rd_id,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_excl,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_excl,
    output logic              wr_permit,
    output logic [1:0]        wr_resp
);
    localparam int SLOTS = 1 << ID_W;

    logic [SLOTS-1:0] hit_vec;
    logic [SLOTS-1:0] arm_vec;
    logic [SLOTS-1:0] disarm_vec;
    exmon_verdict_t   verdict;

    exmon_ctrl #(.ID_W(ID_W)) u_ctrl (
        .rd_valid   (rd_valid),
        .rd_id      (rd_id),
        .rd_excl    (rd_excl),
        .wr_valid   (wr_valid),
        .wr_id      (wr_id),
        .wr_excl    (wr_excl),
        .hit_vec    (hit_vec),
        .arm_vec    (arm_vec),
        .disarm_vec (disarm_vec),
        .verdict    (verdict)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        exmon_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk          (clk),
            .rst          (rst),
            .arm_i        (arm_vec[i]),
            .arm_addr_i   (rd_addr),
            .disarm_i     (disarm_vec[i]),
            .probe_addr_i (wr_addr),
            .hit_o        (hit_vec[i])
        );
    end

    assign wr_permit = verdict.permit;
    assign wr_resp   = verdict.resp;

endmodule

// File: rtl/exmon_chk.sv
module exmon_chk #(
    parameter int ID_W   = 3,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_valid,
    input logic [ID_W-1:0]   rd_id,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_excl,
    input logic              wr_valid,
    input logic [ID_W-1:0]   wr_id,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_excl,
    input logic              wr_permit,
    input logic [1:0]        wr_resp
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    AST_RESP_CODE: assert property (@(posedge clk) disable iff (rst)
        (wr_resp == 2'b00) || (wr_resp == 2'b01 && wr_valid && wr_excl)); // R1

    AST_EXOKAY_PERMITS: assert property (@(posedge clk) disable iff (rst)
        (wr_resp == 2'b01) |-> wr_permit); // R2

    AST_FAIL_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_excl && wr_resp == 2'b00) |-> !wr_permit); // R3

    AST_PLAIN_PASSES: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_excl) |-> (wr_permit && wr_resp == 2'b00)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> !wr_permit); // R7

    AST_REPEAT_FAILS: assert property (@(posedge clk) disable iff (rst)
        (seen && wr_valid && wr_excl &&
         $past(wr_valid && wr_excl && !(rd_valid && rd_excl)) &&
         wr_id == $past(wr_id)) |-> (wr_resp == 2'b00)); // R4

endmodule

bind exmon exmon_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_valid  (rd_valid),
    .rd_id     (rd_id),
    .rd_addr   (rd_addr),
    .rd_excl   (rd_excl),
    .wr_valid  (wr_valid),
    .wr_id     (wr_id),
    .wr_addr   (wr_addr),
    .wr_excl   (wr_excl),
    .wr_permit (wr_permit),
    .wr_resp   (wr_resp)
);

// File: tb/exmon_tb.sv
module exmon_tb;
    localparam int ID_W   = 3;
    localparam int ADDR_W = 16;
    localparam int SLOTS  = 1 << ID_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_valid = 1'b0;
    logic [ID_W-1:0]   rd_id = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_excl = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ID_W-1:0]   wr_id = '0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              wr_excl = 1'b0;
    logic              wr_permit;
    logic [1:0]        wr_resp;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    // Reference table built from the requirements.
    bit                m_armed [SLOTS];
    logic [ADDR_W-1:0] m_addr  [SLOTS];

    always #5 clk = ~clk;

    exmon #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_addr(rd_addr), .rd_excl(rd_excl),
        .wr_valid(wr_valid), .wr_id(wr_id), .wr_addr(wr_addr), .wr_excl(wr_excl),
        .wr_permit(wr_permit), .wr_resp(wr_resp)
    );

    function automatic bit exp_success(input bit v, input bit x,
                                       input logic [ID_W-1:0] id,
                                       input logic [ADDR_W-1:0] a);
        return v && x && m_armed[id] && (m_addr[id] == a);
    endfunction

    function automatic bit exp_permit(input bit v, input bit x,
                                      input logic [ID_W-1:0] id,
                                      input logic [ADDR_W-1:0] a);
        return v && (!x || exp_success(v, x, id, a));
    endfunction

    task automatic check(input string tag, input logic [1:0] act_resp,
                         input logic act_perm, input logic [1:0] e_resp,
                         input logic e_perm);
        n_checks++;
        if (act_resp !== e_resp || act_perm !== e_perm) begin
            n_fails++;
            $display("FAIL %s: resp=%b permit=%b expected resp=%b permit=%b",
                     tag, act_resp, act_perm, e_resp, e_perm);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < SLOTS; i++) begin
            m_armed[i] = 1'b0;
            m_addr[i]  = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rd_valid = 1'b0;
        wr_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // One cycle: drive at the falling edge, check the combinational
    // outputs, then advance the model at the rising edge.
    task automatic cyc(input bit rv, input int rid, input int ra, input bit rx,
                       input bit wv, input int wid, input int wa, input bit wx,
                       input string tag);
        logic [ID_W-1:0]   r_id, w_id;
        logic [ADDR_W-1:0] r_a, w_a;
        bit ok, perm;
        r_id = ID_W'(rid);
        w_id = ID_W'(wid);
        r_a  = ADDR_W'(ra);
        w_a  = ADDR_W'(wa);
        @(negedge clk);
        rd_valid = rv; rd_id = r_id; rd_addr = r_a; rd_excl = rx;
        wr_valid = wv; wr_id = w_id; wr_addr = w_a; wr_excl = wx;
        ok   = exp_success(wv, wx, w_id, w_a);
        perm = exp_permit(wv, wx, w_id, w_a);
        #1;
        check(tag, wr_resp, wr_permit, ok ? 2'b01 : 2'b00, perm);
        @(posedge clk);
        for (int i = 0; i < SLOTS; i++) begin
            bit clr;
            clr = wv && ((wx && w_id == ID_W'(i)) ||
                         (perm && m_armed[i] && m_addr[i] == w_a));
            if (rv && rx && r_id == ID_W'(i)) begin
                m_armed[i] = 1'b1;
                m_addr[i]  = r_a;
            end else if (clr) begin
                m_armed[i] = 1'b0;
            end
        end
    endtask

    task automatic rd_x(input int id, input int a, input string tag);
        cyc(1, id, a, 1, 0, 0, 0, 0, tag);
    endtask

    task automatic wr_x(input int id, input int a, input string tag);
        cyc(0, 0, 0, 0, 1, id, a, 1, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1 idle after reset");
        wr_x(0, 5, "R10 no slot armed after reset");

        // R10: reset in the middle of a reservation
        rd_x(1, 7, "R10 arm");
        do_reset();
        wr_x(1, 7, "R10 reservation cleared by reset");

        // R2, R4
        rd_x(2, 'h10, "R2 arm");
        wr_x(2, 'h10, "R2 matching exclusive write");
        wr_x(2, 'h10, "R4 repeat after success");

        // R3, R4 on failure
        rd_x(3, 'h20, "R3 arm");
        wr_x(3, 'h21, "R3 address mismatch");
        wr_x(3, 'h20, "R4 slot cleared by failed write");

        // R5: plain write by another ID kills reservation
        rd_x(4, 'h30, "R5 arm");
        cyc(0, 0, 0, 0, 1, 5, 'h30, 0, "R7 plain write permitted");
        wr_x(4, 'h30, "R5 reservation lost to plain write");

        // R5: successful exclusive write kills other ID's reservation
        rd_x(4, 'h34, "R5 arm a");
        rd_x(5, 'h34, "R5 arm b");
        wr_x(5, 'h34, "R5 winner");
        wr_x(4, 'h34, "R5 loser");

        // R6: failed exclusive write spares others
        rd_x(4, 'h30, "R6 arm");
        wr_x(5, 'h30, "R6 unarmed writer fails");
        wr_x(4, 'h30, "R6 reservation survives");

        // R8: overwrite
        rd_x(6, 'h40, "R8 arm old");
        rd_x(6, 'h44, "R8 arm new");
        wr_x(6, 'h40, "R8 old address fails");
        rd_x(6, 'h40, "R8 arm old again");
        rd_x(6, 'h44, "R8 arm new again");
        wr_x(6, 'h44, "R8 new address succeeds");

        // R9: plain read ignored
        rd_x(7, 'h50, "R9 arm");
        cyc(1, 7, 'h60, 0, 0, 0, 0, 0, "R9 plain read");
        wr_x(7, 'h50, "R9 reservation untouched");

        // R11: same-cycle collisions
        rd_x(1, 'h70, "R11 arm");
        cyc(1, 1, 'h70, 1, 1, 2, 'h70, 0, "R11 plain write with re-arm");
        wr_x(1, 'h70, "R11 re-arm wins");
        rd_x(1, 'h74, "R11 arm b");
        cyc(1, 1, 'h78, 1, 1, 1, 'h74, 1, "R11 judged on old table");
        wr_x(1, 'h78, "R11 same-cycle read re-arms own slot");

        // R12: independence
        rd_x(0, 'h80, "R12 arm a");
        rd_x(1, 'h90, "R12 arm b");
        cyc(0, 0, 0, 0, 1, 3, 'h91, 0, "R12 unrelated plain write");
        wr_x(0, 'h80, "R12 slot a intact");
        wr_x(1, 'h90, "R12 slot b intact");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit rv, rx, wv, wx;
            int rid, ra, wid, wa;
            string tag;
            rv  = ($urandom % 2) == 0;
            rx  = ($urandom % 3) != 0;
            wv  = ($urandom % 2) == 0;
            wx  = ($urandom % 3) != 0;
            rid = int'($urandom % SLOTS);
            wid = int'($urandom % SLOTS);
            ra  = int'($urandom % 4);
            wa  = int'($urandom % 4);
            if (!wv || !wx) tag = "R7 random";
            else tag = "R2/R3 random exclusive";
            cyc(rv, rid, ra, rx, wv, wid, wa, wx, tag);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule